// File: doc/BRIEF.md
# Branch Condition Code Evaluator

This block decides whether a conditional jump or call is taken. Each cycle it reads a 4-bit condition selector together with five status flags: zero, overflow, negative, carry (which holds the borrow after a compare) and end-of-table. It returns one registered bit, `taken_q`, that is high when the selected condition holds for the flags sampled at the previous rising clock edge.

The conditions cover an always-taken code, set and clear tests on each of the four arithmetic flags, equality and inequality, the unsigned and signed magnitude relations, and a table-search condition. That last condition holds only when the compared operands differ and the end-of-table flag is clear. Equal shares its code with zero set, and not-equal shares its code with zero clear. Unsigned lower shares its code with carry set, and unsigned higher-or-same shares its code with carry clear. The single code left over is reserved and never taken.

The surrounding fetch logic presents the selector and the current flag word. One cycle later it uses `taken_q` to pick between the sequential address and the branch target.

Top module: `bcc_eval`

## Requirements
- R1: While `rst` is high at a rising edge, `taken_q` is 0 after that edge.
- R2: `taken_q` reflects `cond_sel` and the flags sampled at the previous rising edge. A change on the inputs between edges does not change `taken_q`.
- R3: Code 0x0 is always taken, whatever the flags.
- R4: Codes 0x3/0x4 are taken when overflow is set/clear, codes 0x5/0x6 when negative is set/clear, and codes 0x7/0x8 when carry is set/clear.
- R5: Code 0x1 (equal, zero set) is taken when `flag_z` is 1. Code 0x2 (not equal, zero clear) is taken when `flag_z` is 0.
- R6: Unsigned relations. 0x7 lower: C=1. 0x8 higher-or-same: C=0. 0x9 lower-or-same: C=1 or Z=1. 0xA higher: C=0 and Z=0.
- R7: Signed relations, where less = N xor V. 0xB less-or-equal: less or Z=1. 0xC greater-or-equal: not less. 0xD greater: not less and Z=0.
- R8: Code 0xE (table search) is taken only when `flag_z` = 0 and `flag_end` = 0.
- R9: Code 0xF is reserved and is never taken.
- R10: Flags that the selected condition does not use have no effect on `taken_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond_sel | input | SEL_W (4) | Condition selector code |
| flag_z | input | 1 | Zero / equal flag |
| flag_v | input | 1 | Overflow flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry / borrow flag |
| flag_end | input | 1 | End-of-table flag |
| taken_q | output | 1 | Registered branch decision |

## Verification
The only state in the block is the output register. A fault in the relation logic or in the code table therefore shows up on `taken_q` one edge after the faulty selector and flag combination is presented, and it clears again once the inputs change. The bench drives every selector code against all 32 flag combinations, so any wrong entry in the table appears on the next cycle. A second test changes the inputs between edges and confirms that the output holds its value until the edge.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [3:0] {
    COND_ALWAYS = 4'h0,
    COND_ZSET   = 4'h1,
    COND_ZCLR   = 4'h2,
    COND_VSET   = 4'h3,
    COND_VCLR   = 4'h4,
    COND_NSET   = 4'h5,
    COND_NCLR   = 4'h6,
    COND_CSET   = 4'h7,
    COND_CCLR   = 4'h8,
    COND_ULE    = 4'h9,
    COND_UGT    = 4'hA,
    COND_SLE    = 4'hB,
    COND_SGE    = 4'hC,
    COND_SGT    = 4'hD,
    COND_TBL    = 4'hE,
    COND_RSVD   = 4'hF
  } cond_code_e;

  typedef struct packed {
    logic e;
    logic c;
    logic n;
    logic v;
    logic z;
  } flags_t;

  typedef struct packed {
    logic ule;
    logic ugt;
    logic sle;
    logic sge;
    logic sgt;
    logic tbl;
  } rel_t;

endpackage

// File: rtl/bcc_relations.sv
module bcc_relations
  import bcc_pkg::*;
(
  input  flags_t flg,
  output rel_t   rel
);

  logic s_less;

  always_comb begin
    s_less  = flg.n ^ flg.v;
    rel.ule = flg.c | flg.z;
    rel.ugt = ~flg.c & ~flg.z;
    rel.sle = s_less | flg.z;
    rel.sge = ~s_less;
    rel.sgt = ~s_less & ~flg.z;
    rel.tbl = ~flg.z & ~flg.e;
  end

endmodule

// File: rtl/bcc_table.sv
module bcc_table
  import bcc_pkg::*;
#(
  parameter int unsigned NUM_CODES = 16
) (
  input  rel_t                 rel,
  input  flags_t               flg,
  output logic [NUM_CODES-1:0] hit_vec
);

  function automatic logic code_hit(input int unsigned idx, input rel_t r, input flags_t f);
    logic res;
    case (idx)
      int'(COND_ALWAYS): res = 1'b1;
      int'(COND_ZSET):   res = f.z;
      int'(COND_ZCLR):   res = ~f.z;
      int'(COND_VSET):   res = f.v;
      int'(COND_VCLR):   res = ~f.v;
      int'(COND_NSET):   res = f.n;
      int'(COND_NCLR):   res = ~f.n;
      int'(COND_CSET):   res = f.c;
      int'(COND_CCLR):   res = ~f.c;
      int'(COND_ULE):    res = r.ule;
      int'(COND_UGT):    res = r.ugt;
      int'(COND_SLE):    res = r.sle;
      int'(COND_SGE):    res = r.sge;
      int'(COND_SGT):    res = r.sgt;
      int'(COND_TBL):    res = r.tbl;
      default:           res = 1'b0;
    endcase
    return res;
  endfunction

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
    assign hit_vec[i] = code_hit(i, rel, flg);
  end

endmodule

// File: rtl/bcc_select.sv
module bcc_select #(
  parameter int unsigned SEL_W = 4,
  localparam int unsigned NUM_CODES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic [NUM_CODES-1:0] hit_vec,
  output logic                 taken_d
);

  assign taken_d = hit_vec[sel];

endmodule

// File: rtl/bcc_eval.sv
module bcc_eval
  import bcc_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] cond_sel,
  input  logic             flag_z,
  input  logic             flag_v,
  input  logic             flag_n,
  input  logic             flag_c,
  input  logic             flag_end,
  output logic             taken_q
);

  localparam int unsigned NUM_CODES = 1 << SEL_W;

  flags_t                 flg;
  rel_t                   rel;
  logic [NUM_CODES-1:0]   hit_vec;
  logic                   taken_d;

  assign flg = '{e: flag_end, c: flag_c, n: flag_n, v: flag_v, z: flag_z};

  bcc_relations u_rel (
    .flg (flg),
    .rel (rel)
  );

  bcc_table #(.NUM_CODES(NUM_CODES)) u_table (
    .rel     (rel),
    .flg     (flg),
    .hit_vec (hit_vec)
  );

  bcc_select #(.SEL_W(SEL_W)) u_sel (
    .sel     (cond_sel),
    .hit_vec (hit_vec),
    .taken_d (taken_d)
  );

  always_ff @(posedge clk) begin
    if (rst) taken_q <= 1'b0;
    else     taken_q <= taken_d;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !taken_q);

  // R3
  always_code_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == SEL_W'(COND_ALWAYS)) |=> taken_q);

  // R5
  eq_follows_z_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == SEL_W'(COND_ZSET)) |=> (taken_q == $past(flag_z)));

  // R7
  sge_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == SEL_W'(COND_SGE)) |=> (taken_q == ($past(flag_n) == $past(flag_v))));

  // R8
  table_end_chk: assert property (@(posedge clk) disable iff (rst)
    ((cond_sel == SEL_W'(COND_TBL)) && flag_end) |=> !taken_q);

  // R9
  reserved_code_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_sel == SEL_W'(COND_RSVD)) |=> !taken_q);

endmodule

// File: tb/bcc_eval_bench.sv
module bcc_eval_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] cond_sel;
  logic       flag_z, flag_v, flag_n, flag_c, flag_end;
  logic       taken_q;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  bcc_eval u_bcc_eval (
    .clk      (clk),
    .rst      (rst),
    .cond_sel (cond_sel),
    .flag_z   (flag_z),
    .flag_v   (flag_v),
    .flag_n   (flag_n),
    .flag_c   (flag_c),
    .flag_end (flag_end),
    .taken_q  (taken_q)
  );

  function automatic logic expect_taken(input logic [3:0] s, input logic [4:0] f);
    logic z, v, n, c, e, lt;
    z = f[0]; v = f[1]; n = f[2]; c = f[3]; e = f[4];
    lt = n ^ v;
    case (s)
      4'h0: return 1'b1;
      4'h1: return z;
      4'h2: return !z;
      4'h3: return v;
      4'h4: return !v;
      4'h5: return n;
      4'h6: return !n;
      4'h7: return c;
      4'h8: return !c;
      4'h9: return c || z;
      4'hA: return !c && !z;
      4'hB: return lt || z;
      4'hC: return !lt;
      4'hD: return !lt && !z;
      4'hE: return !z && !e;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic got, input logic exp, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] s, input logic [4:0] f);
    @(negedge clk);
    cond_sel = s;
    {flag_end, flag_c, flag_n, flag_v, flag_z} = f;
  endtask

  task automatic apply_check(input string req, input logic [3:0] s, input logic [4:0] f);
    drive(s, f);
    @(posedge clk);
    #2;
    check(req, taken_q, expect_taken(s, f), $sformatf("sel=%h flags=%b", s, f));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    drive(4'h0, 5'b0);
    @(posedge clk); #2;
    check("R1", taken_q, 1'b0, "reset with always code");
    @(posedge clk); #2;
    check("R1", taken_q, 1'b0, "reset held");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_always;
    for (int f = 0; f < 32; f++) apply_check("R3", 4'h0, 5'(f));
  endtask

  task automatic t_single;
    for (int s = 3; s <= 8; s++)
      for (int f = 0; f < 32; f++) apply_check("R4", 4'(s), 5'(f));
  endtask

  task automatic t_equality;
    for (int s = 1; s <= 2; s++)
      for (int f = 0; f < 32; f++) apply_check("R5", 4'(s), 5'(f));
  endtask

  task automatic t_unsigned;
    for (int s = 7; s <= 10; s++)
      for (int f = 0; f < 32; f++) apply_check("R6", 4'(s), 5'(f));
  endtask

  task automatic t_signed;
    for (int s = 11; s <= 13; s++)
      for (int f = 0; f < 32; f++) apply_check("R7", 4'(s), 5'(f));
  endtask

  task automatic t_table;
    for (int f = 0; f < 32; f++) apply_check("R8", 4'hE, 5'(f));
  endtask

  task automatic t_reserved;
    for (int f = 0; f < 32; f++) apply_check("R9", 4'hF, 5'(f));
  endtask

  task automatic t_ignored;
    // R10: overflow code with Z,N,C,E toggled around a fixed V
    for (int f = 0; f < 32; f++) begin
      drive(4'h3, 5'(f));
      @(posedge clk); #2;
      check("R10", taken_q, f[1], $sformatf("overflow code flags=%b", 5'(f)));
    end
    // R10: table code ignores V, N and C
    for (int f = 0; f < 8; f++) begin
      drive(4'hE, {1'b0, 3'(f), 1'b0});
      @(posedge clk); #2;
      check("R10", taken_q, 1'b1, $sformatf("table code vnc=%b", 3'(f)));
    end
  endtask

  task automatic t_latency;
    drive(4'h0, 5'b0);
    @(posedge clk); #2;
    check("R2", taken_q, 1'b1, "always sampled");
    drive(4'hF, 5'b0);
    #1;
    check("R2", taken_q, 1'b1, "holds before edge");
    @(posedge clk); #2;
    check("R2", taken_q, 1'b0, "updates after edge");
    drive(4'h1, 5'b00001);
    #1;
    check("R2", taken_q, 1'b0, "holds before edge 2");
    @(posedge clk); #2;
    check("R2", taken_q, 1'b1, "updates after edge 2");
  endtask

  initial begin
    cond_sel = 4'h0;
    {flag_end, flag_c, flag_n, flag_v, flag_z} = 5'b0;
    t_reset();
    t_always();
    t_single();
    t_equality();
    t_unsigned();
    t_signed();
    t_table();
    t_reserved();
    t_ignored();
    t_latency();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule